// File: doc/BRIEF.md
# Token-Loss Reconfiguration Sequencer

This block watches a token-passing bus for signs that the token has vanished and, when it has, drives the sequence that rebuilds the logical ring. It measures how long the line has stayed quiet. After a long enough silence it runs an arbitration wait whose length depends on the node's own address. When that wait ends uncontested, it takes control and invites successor addresses one after another until one of them answers. A separate watchdog flags the case where this node never receives the token while the line stays busy.

All timing is counted in ticks of an external 1 µs strobe. The thresholds are parameters whose defaults give the usual microsecond values. The block only sequences timers and keeps the successor address. Frame building, checksums and the line driver are handled elsewhere, and they act on the invitation request this block raises.

Top module: `rcs_recon_seq`

## Requirements
- R1: After reset, `itt_req`, `recon_start` and `recon_flag` are 0 and `next_id` is 1.
- R2: While `node_id` is 0 the block is dormant. From the cycle after it sees 0, it raises no `itt_req` and no `recon_start`, and `recon_flag` is 0. When `node_id` becomes non-zero, monitoring begins one cycle later with every timer at zero.
- R3: While monitoring, IDLE_TICKS consecutive ticks with `line_active` and `token_rx` both low start the arbitration wait. Any cycle with activity or a token restarts the count.
- R4: The arbitration wait ends on its ARB_UNIT_TICKS × (255 − `node_id`)-th tick. At that point `next_id` takes the value of `node_id` (one cycle after the final tick) and the node takes control.
- R5: A cycle with `line_active` high during the arbitration wait abandons it and returns to monitoring with the idle count at zero. `next_id` keeps its value.
- R6: One cycle after the node takes control, `itt_req` pulses for exactly one cycle. In the same cycle `next_id` shows the previous value plus one.
- R7: After each invitation, RESP_TICKS ticks with no line activity cause the next invitation. `next_id` steps from 255 to 1 and is never 0.
- R8: Line activity during the response window keeps the current `next_id` as the successor and returns to monitoring. After that, each `token_rx` pulse produces an `itt_req` pulse in the next cycle with `next_id` unchanged.
- R9: While monitoring, RECON_TICKS ticks without a `token_rx` pulse produce a one-cycle `recon_start` pulse and set `recon_flag`. The flag stays set until reset or a zero `node_id`, and the idle count restarts.
- R10: Timers advance only in cycles where `tick_us` is high. A cycle with `tick_us` low leaves every count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe each microsecond |
| line_active | input | 1 | High while activity is detected on the line |
| token_rx | input | 1 | One-cycle strobe when this node receives the token |
| node_id | input | 8 | Programmed address of this node; 0 means dormant |
| itt_req | output | 1 | One-cycle request to send an invitation to `next_id` |
| next_id | output | 8 | Current successor or candidate address |
| recon_flag | output | 1 | Sticky: this node caused a reconfiguration |
| recon_start | output | 1 | One-cycle strobe when this node starts a reconfiguration |

## Verification
A behavioural model in the bench predicts all four outputs for every clock. A corrupted state or counter therefore shows up at the ports within one cycle of the first divergent output: an invitation one tick early or late, a `next_id` off by one or taking the value 0, or a strobe that appears or goes missing. Timer thresholds are exercised with shortened parameters, including ticks spaced three cycles apart, a contested arbitration, a response that arrives in the third window, and a scan that steps past 255.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam int ID_W   = 8;
    localparam int ID_TOP = 255;

    typedef enum logic [2:0] {
        ST_DORMANT   = 3'd0,
        ST_MONITOR   = 3'd1,
        ST_ARBITRATE = 3'd2,
        ST_INVITE    = 3'd3,
        ST_LISTEN    = 3'd4
    } rcs_state_e;

    typedef struct packed {
        rcs_state_e        state;
        logic [ID_W-1:0]   succ_id;
        logic              have_succ;
        logic              mine;
        logic              invite;
        logic              kick;
    } rcs_ctl_t;

    // successor candidate step: 255 wraps to 1, zero is skipped
    function automatic logic [ID_W-1:0] id_step(input logic [ID_W-1:0] v);
        return (v == ID_W'(ID_TOP)) ? ID_W'(1) : v + ID_W'(1);
    endfunction

endpackage

// File: rtl/rcs_tick_timer.sv
module rcs_tick_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt_q, cnt_d;
    logic [W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
        hit     = run && (cnt_inc >= {1'b0, limit});
        cnt_d   = cnt_q;
        if (clr || hit) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = cnt_inc[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // a window that ends starts the next one from zero
    assert_hit_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == '0));

endmodule

// File: rtl/rcs_arb_span.sv
module rcs_arb_span #(
    parameter int UNIT = 1168,
    parameter int AW   = 19
) (
    input  logic [rcs_pkg::ID_W-1:0] id,
    output logic [AW-1:0]            span
);

    logic [rcs_pkg::ID_W-1:0] gap;

    always_comb begin
        gap  = rcs_pkg::ID_W'(rcs_pkg::ID_TOP) - id;
        span = AW'(UNIT) * AW'(gap);
    end

endmodule

// File: rtl/rcs_recon_seq.sv
module rcs_recon_seq #(
    parameter int IDLE_TICKS     = 657,
    parameter int ARB_UNIT_TICKS = 1168,
    parameter int RESP_TICKS     = 598,
    parameter int RECON_TICKS    = 840000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       line_active,
    input  logic       token_rx,
    input  logic [7:0] node_id,
    output logic       itt_req,
    output logic [7:0] next_id,
    output logic       recon_flag,
    output logic       recon_start
);
    import rcs_pkg::*;

    localparam int IW = $clog2(IDLE_TICKS + 1);
    localparam int AW = $clog2(ARB_UNIT_TICKS * ID_TOP + 1);
    localparam int RW = $clog2(RESP_TICKS + 1);
    localparam int CW = $clog2(RECON_TICKS + 1);

    rcs_ctl_t q, d;

    logic          awake;
    logic          in_mon, in_arb, in_lis;
    logic          idle_hit, arb_hit, resp_hit, recon_hit;
    logic [AW-1:0] arb_span;

    assign awake  = (node_id != '0);
    assign in_mon = (q.state == ST_MONITOR);
    assign in_arb = (q.state == ST_ARBITRATE);
    assign in_lis = (q.state == ST_LISTEN);

    // silence detector
    rcs_tick_timer #(.W(IW)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_mon || line_active || token_rx || recon_hit),
        .run   (in_mon && tick_us && !line_active && !token_rx),
        .limit (IW'(IDLE_TICKS)),
        .hit   (idle_hit)
    );

    // token-reception watchdog
    rcs_tick_timer #(.W(CW)) u_recon (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_mon || token_rx),
        .run   (in_mon && tick_us && !token_rx),
        .limit (CW'(RECON_TICKS)),
        .hit   (recon_hit)
    );

    rcs_arb_span #(.UNIT(ARB_UNIT_TICKS), .AW(AW)) u_span (
        .id   (node_id),
        .span (arb_span)
    );

    // address-weighted arbitration wait
    rcs_tick_timer #(.W(AW)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_arb || line_active),
        .run   (in_arb && tick_us && !line_active),
        .limit (arb_span),
        .hit   (arb_hit)
    );

    // response window after each invitation
    rcs_tick_timer #(.W(RW)) u_resp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_lis || line_active),
        .run   (in_lis && tick_us && !line_active),
        .limit (RW'(RESP_TICKS)),
        .hit   (resp_hit)
    );

    always_comb begin
        d        = q;
        d.invite = 1'b0;
        d.kick   = 1'b0;
        if (!awake) begin
            d.state     = ST_DORMANT;
            d.mine      = 1'b0;
            d.have_succ = 1'b0;
        end else begin
            unique case (q.state)
                ST_DORMANT: begin
                    d.state = ST_MONITOR;
                end
                ST_MONITOR: begin
                    if (token_rx && q.have_succ) begin
                        d.invite = 1'b1;
                    end
                    if (recon_hit) begin
                        d.kick = 1'b1;
                        d.mine = 1'b1;
                    end else if (idle_hit) begin
                        d.state = ST_ARBITRATE;
                    end
                end
                ST_ARBITRATE: begin
                    if (line_active) begin
                        d.state = ST_MONITOR;
                    end else if (arb_hit) begin
                        d.succ_id   = node_id;
                        d.have_succ = 1'b0;
                        d.state     = ST_INVITE;
                    end
                end
                ST_INVITE: begin
                    d.succ_id = id_step(q.succ_id);
                    d.invite  = 1'b1;
                    d.state   = ST_LISTEN;
                end
                ST_LISTEN: begin
                    if (line_active) begin
                        d.have_succ = 1'b1;
                        d.state     = ST_MONITOR;
                    end else if (resp_hit) begin
                        d.state = ST_INVITE;
                    end
                end
                default: begin
                    d.state = ST_DORMANT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_DORMANT;
            q.succ_id   <= ID_W'(1);
            q.have_succ <= 1'b0;
            q.mine      <= 1'b0;
            q.invite    <= 1'b0;
            q.kick      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign itt_req     = q.invite;
    assign next_id     = q.succ_id;
    assign recon_flag  = q.mine;
    assign recon_start = q.kick;

    assert_nid_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        next_id != '0);

    assert_dormant_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (node_id == '0) |=> (!itt_req && !recon_start && !recon_flag));

    assert_flag_with_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recon_start |-> recon_flag);

    assert_invite_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_INVITE && awake) |=>
            (itt_req && (($past(next_id) == 8'd255) ? (next_id == 8'd1)
                                                    : (next_id == $past(next_id) + 8'd1))));

    assert_arb_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_arb && line_active && awake) |=> (q.state == ST_MONITOR && $stable(next_id)));

endmodule

// File: tb/tb_rcs_recon_seq.sv
module tb_rcs_recon_seq;

    localparam int P_IDLE  = 12;
    localparam int P_UNIT  = 3;
    localparam int P_RESP  = 5;
    localparam int P_RECON = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic       line_active = 1'b0;
    logic       token_rx = 1'b0;
    logic [7:0] node_id = 8'd0;
    logic       itt_req;
    logic [7:0] next_id;
    logic       recon_flag;
    logic       recon_start;

    always #10 clk = ~clk;

    rcs_recon_seq #(
        .IDLE_TICKS     (P_IDLE),
        .ARB_UNIT_TICKS (P_UNIT),
        .RESP_TICKS     (P_RESP),
        .RECON_TICKS    (P_RECON)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_us     (tick_us),
        .line_active (line_active),
        .token_rx    (token_rx),
        .node_id     (node_id),
        .itt_req     (itt_req),
        .next_id     (next_id),
        .recon_flag  (recon_flag),
        .recon_start (recon_start)
    );

    // behavioural reference: modes 0 sleep, 1 watch, 2 contend, 3 invite, 4 listen
    int m_st = 0, m_nid = 1, m_idle = 0, m_rc = 0, m_arb = 0, m_resp = 0;
    bit m_flag = 0, m_succ = 0, m_itt = 0, m_rs = 0;
    int lim;
    bit rec;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_nid = 1; m_flag = 0; m_succ = 0; m_itt = 0; m_rs = 0;
            m_idle = 0; m_rc = 0; m_arb = 0; m_resp = 0;
        end else begin
            m_itt = 0;
            m_rs  = 0;
            if (node_id == 0) begin
                m_st = 0; m_flag = 0; m_succ = 0;
            end else begin
                case (m_st)
                    0: begin m_st = 1; m_idle = 0; m_rc = 0; end
                    1: begin
                        rec = 0;
                        if (token_rx) begin
                            m_rc = 0;
                            if (m_succ) m_itt = 1;
                        end else if (tick_us) begin
                            if (m_rc + 1 >= P_RECON) begin
                                m_rc = 0; m_rs = 1; m_flag = 1; rec = 1;
                            end else m_rc++;
                        end
                        if (rec || line_active || token_rx) m_idle = 0;
                        else if (tick_us) begin
                            if (m_idle + 1 >= P_IDLE) begin
                                m_st = 2; m_idle = 0; m_arb = 0;
                            end else m_idle++;
                        end
                    end
                    2: begin
                        lim = P_UNIT * (255 - int'(node_id));
                        if (line_active) begin
                            m_st = 1; m_idle = 0; m_rc = 0;
                        end else if (tick_us) begin
                            if (m_arb + 1 >= lim) begin
                                m_nid = node_id; m_succ = 0; m_st = 3;
                            end else m_arb++;
                        end
                    end
                    3: begin
                        m_nid = (m_nid == 255) ? 1 : m_nid + 1;
                        m_itt = 1; m_st = 4; m_resp = 0;
                    end
                    default: begin
                        if (line_active) begin
                            m_succ = 1; m_st = 1; m_idle = 0; m_rc = 0;
                        end else if (tick_us) begin
                            if (m_resp + 1 >= P_RESP) m_st = 3;
                            else m_resp++;
                        end
                    end
                endcase
            end
        end
    end

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";
    int    tick_per = 1;
    int    tick_phase = 0;
    int    rs_seen = 0;
    int    itt_log[$];
    bit    done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (rst_n) begin
            vectors++;
            if (itt_req !== m_itt || next_id !== 8'(m_nid) ||
                recon_flag !== m_flag || recon_start !== m_rs) begin
                miscompares++;
                $display("FAIL %s actual itt=%0b nid=%0d flag=%0b rs=%0b expected itt=%0b nid=%0d flag=%0b rs=%0b",
                         cur_req, itt_req, next_id, recon_flag, recon_start,
                         m_itt, m_nid, m_flag, m_rs);
            end
            if (itt_req === 1'b1) itt_log.push_back(int'(next_id));
            if (recon_start === 1'b1) rs_seen++;
        end
        tick_us = ((tick_phase % tick_per) == 0);
        tick_phase++;
    endtask

    task automatic busy(input int n);
        for (int i = 0; i < n; i++) begin
            line_active = ((i % 6) == 5);
            cyc();
        end
        line_active = 1'b0;
    endtask

    task automatic quiet(input int n);
        line_active = 1'b0;
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : main
        int calls;
        // R1: reset values
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();
        check(itt_req == 1'b0 && recon_start == 1'b0, "R1", itt_req, 0);
        check(recon_flag == 1'b0, "R1", recon_flag, 0);
        check(next_id == 8'd1, "R1", next_id, 1);

        // R2: dormant with a zero address, line silent
        cur_req = "R2";
        itt_log.delete();
        quiet(40);
        check(itt_log.size() == 0, "R2", itt_log.size(), 0);
        check(recon_flag == 1'b0, "R2", recon_flag, 0);

        // R3: activity every 6 cycles keeps arbitration away
        cur_req = "R3";
        node_id = 8'd250;
        busy(60);
        check(itt_log.size() == 0, "R3", itt_log.size(), 0);

        // R4: silence 12 ticks, then 15 ticks of contention, invite on call 28
        cur_req = "R4";
        calls = 0;
        while (itt_log.size() == 0 && calls < 100) begin
            cyc();
            calls++;
            if (calls == 27) check(next_id == 8'd250, "R4", next_id, 250);
        end
        check(calls == 28, "R4", calls, 28);

        // R6 / R7: unanswered invitations step the candidate
        cur_req = "R7";
        calls = 0;
        while (itt_log.size() < 3 && calls < 100) begin
            cyc();
            calls++;
        end
        check(itt_log.size() == 3 && itt_log[0] == 251, "R6", itt_log[0], 251);
        check(itt_log.size() == 3 && itt_log[2] == 253, "R7", itt_log[2], 253);

        // R8: answer the third invitation, then pass the token
        cur_req = "R8";
        line_active = 1'b1;
        cyc();
        itt_log.delete();
        busy(24);
        check(itt_log.size() == 0 && next_id == 8'd253, "R8", next_id, 253);
        token_rx = 1'b1;
        cyc();
        token_rx = 1'b0;
        check(itt_req == 1'b1 && next_id == 8'd253, "R8", next_id, 253);
        busy(12);

        // R10: ticks every third cycle, 10 ticks of silence is short of 12
        cur_req = "R10";
        tick_per = 3;
        tick_phase = 0;
        itt_log.delete();
        quiet(30);
        check(itt_log.size() == 0, "R10", itt_log.size(), 0);
        quiet(90);
        tick_per = 1;
        busy(24);

        // R9: busy line, no token, watchdog fires
        cur_req = "R9";
        rs_seen = 0;
        busy(480);
        check(rs_seen >= 1, "R9", rs_seen, 1);
        check(recon_flag == 1'b1, "R9", recon_flag, 1);
        busy(12);
        check(recon_flag == 1'b1, "R9", recon_flag, 1);

        // R5: contention abandoned by activity
        cur_req = "R5";
        itt_log.delete();
        calls = int'(next_id);
        quiet(17);
        line_active = 1'b1;
        cyc();
        line_active = 1'b0;
        busy(24);
        check(itt_log.size() == 0, "R5", itt_log.size(), 0);
        check(int'(next_id) == calls, "R5", next_id, calls);

        // R7: wrap past 255
        cur_req = "R7";
        node_id = 8'd253;
        itt_log.delete();
        calls = 0;
        while (itt_log.size() < 5 && calls < 300) begin
            cyc();
            calls++;
        end
        check(itt_log.size() == 5 && itt_log[1] == 255, "R7", itt_log[1], 255);
        check(itt_log.size() == 5 && itt_log[2] == 1, "R7", itt_log[2], 1);
        check(itt_log.size() == 5 && itt_log[4] == 3, "R7", itt_log[4], 3);

        // R2: zero address clears the flag and silences the block
        cur_req = "R2";
        node_id = 8'd0;
        itt_log.delete();
        quiet(20);
        check(recon_flag == 1'b0, "R2", recon_flag, 0);
        check(itt_log.size() == 0, "R2", itt_log.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule